// File: doc/BRIEF.md
# Host Byte/Word Data Port with Read-Ahead and Write FIFOs

This block is the host-facing data register of a packet buffer. It sits between a 16-bit host bus and a byte-wide buffer memory. Host writes enter a small write FIFO, and a sequencer drains that FIFO into memory one byte at a time. In read mode the same sequencer fills a read-ahead FIFO from memory, so host reads are normally served at once. The host can use whole 16-bit words or single bytes on either lane, and can mix them freely. The stream keeps strict byte order, whether the pointer is even or odd.

Software loads a buffer pointer together with a direction bit and an auto-increment bit. A pointer load empties the read-ahead FIFO, and prefetch then starts again from the new address. The host strobe is held until the block raises `hst_rdy`. A read waits while too few bytes are buffered. A write waits while the write FIFO has no room. A pointer load waits until every written byte has reached memory.

The memory sequencer has four states:
- `ST_IDLE` arbitrates between the two FIFOs. It goes to `ST_WRITE` when write data is pending. Otherwise it goes to `ST_FETCH` when in read mode with room in the read-ahead FIFO. Otherwise it stays in `ST_IDLE`.
- `ST_WRITE` stores one byte and returns to `ST_IDLE`.
- `ST_FETCH` issues one read and moves to `ST_LAND`. A pointer load in that cycle sends it back to `ST_IDLE` instead.
- `ST_LAND` pushes the returned byte unless a pointer load arrives in the same cycle, then returns to `ST_IDLE`.

Top module: `dport_top`

## Requirements
- R1: Host accesses reach the data register only when `hst_addr[3:2]` is `2'b10` (offsets 8 through 0xB, two word locations). At any other address a strobe moves no data and `hst_rdy` is 1.
- R2: Transfer size comes from `{hst_addr[0], hst_nbhe}`:
  - `00` is a word: the earlier byte is on bits 7:0 and the later byte on bits 15:8.
  - `01` is one byte on the low lane (bits 7:0).
  - `10` is one byte on the high lane (bits 15:8).
  - `11` moves nothing.
- R3: Written bytes reach memory in the order the host supplied them, one byte per memory write cycle.
- R4: Read data comes back in memory order for any mix of word and byte reads. A byte read places its byte on the lane given by R2 and drives the other lane with zero.
- R5: Word reads and writes keep byte order when the pointer is odd.
- R6: With auto-increment on, the pointer grows by one for every byte moved between a FIFO and memory, and that byte uses the pointer value held before the step.
- R7: With auto-increment off, the pointer keeps its loaded value. Successive bytes use `{ptr[AW-1:1], t}`, where `t` starts at 0 after each load and toggles with every byte moved.
- R8: In read mode the read-ahead FIFO fills up to its depth (4 bytes) and then stops fetching. In write mode no memory read is issued.
- R9: A pointer load empties the read-ahead FIFO and discards a fetch already in flight, so the next read returns data from the new pointer.
- R10: A read needing more bytes than the read-ahead FIFO holds is stalled with `hst_rdy` low, and completes with correct data once the bytes arrive.
- R11: A write needing more room than the write FIFO has is stalled with `hst_rdy` low. A pointer load is stalled until the write FIFO has drained.
- R12: After reset the pointer is 0, the block is in write mode with auto-increment off, no memory access is driven, and `hst_rdy` is 1 when no strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 4 | Host register offset |
| hst_nbhe | input | 1 | Active-low high-byte enable |
| hst_wr | input | 1 | Host write strobe, held until ready |
| hst_rd | input | 1 | Host read strobe, held until ready |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid while a read is ready |
| hst_rdy | output | 1 | Access completes at the clock edge where this is 1 |
| ptr_ld | input | 1 | Pointer load request, held until ready |
| ptr_val | input | AW | New pointer value |
| ptr_rd_mode | input | 1 | Loaded direction: 1 read, 0 write |
| ptr_autoinc | input | 1 | Loaded auto-increment enable |
| ptr_cur | output | AW | Current pointer value |
| mem_addr | output | AW | Buffer memory byte address |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_wdata | output | 8 | Buffer memory write byte |
| mem_re | output | 1 | Buffer memory read strobe (data returns next cycle) |
| mem_rdata | input | 8 | Buffer memory read byte |

## Verification
Assertions watch several rules on every cycle:
- neither FIFO ever overflows or underflows;
- a memory write happens only while the write FIFO holds data;
- the pointer steps by exactly one per moved byte with auto-increment on, and holds still with it off;
- memory reads occur only in read mode;
- the read-ahead FIFO is empty the cycle after a pointer load.

Only the bench's scenarios can show the ordering results. These are the byte order of mixed word and byte streams at even and odd pointers, and the placement of bytes on the host lanes. The bench also shows that ignored addresses leave memory untouched, that a discarded in-flight fetch never reaches the host, and that stalls end with the right data.

// File: rtl/dp_pkg.sv
package dp_pkg;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_LO   = 2'd1,
        LANE_HI   = 2'd2,
        LANE_WORD = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FETCH = 2'd2,
        ST_LAND  = 2'd3
    } mst_e;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
    import dp_pkg::*;
(
    input  logic [3:0] addr,
    input  logic       nbhe,
    output logic       sel,
    output lane_e      lane,
    output logic [1:0] nbytes
);

    // both word locations of the window select the same register
    always_comb begin
        sel = (addr[3:1] == 3'b100) || (addr[3:1] == 3'b101);
    end

    always_comb begin
        unique case ({addr[0], nbhe})
            2'b00: begin lane = LANE_WORD; nbytes = 2'd2; end
            2'b01: begin lane = LANE_LO;   nbytes = 2'd1; end
            2'b10: begin lane = LANE_HI;   nbytes = 2'd1; end
            default: begin lane = LANE_NONE; nbytes = 2'd0; end
        endcase
        if (!sel) begin
            lane   = LANE_NONE;
            nbytes = 2'd0;
        end
    end

endmodule

// File: rtl/dp_fifo.sv
module dp_fifo #(
    parameter int DEPTH = 4,
    parameter int HEADS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [1:0]                   push_n,
    input  logic [7:0]                   push_b0,
    input  logic [7:0]                   push_b1,
    input  logic [1:0]                   pop_n,
    output logic [8*HEADS-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    slot [DEPTH];
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] rd_idx;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] i);
        return (i == PW'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) slot[wr_idx] <= push_b0;
        if (push_n == 2'd2) slot[nxt(wr_idx)] <= push_b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            unique case (push_n)
                2'd1:    wr_idx <= nxt(wr_idx);
                2'd2:    wr_idx <= nxt(nxt(wr_idx));
                default: wr_idx <= wr_idx;
            endcase
            unique case (pop_n)
                2'd1:    rd_idx <= nxt(rd_idx);
                2'd2:    rd_idx <= nxt(nxt(rd_idx));
                default: rd_idx <= rd_idx;
            endcase
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    generate
        if (HEADS == 2) begin : g_two
            assign head = {slot[nxt(rd_idx)], slot[rd_idx]};
        end else begin : g_one
            assign head = slot[rd_idx];
        end
    endgenerate

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush || (int'(count) + int'(push_n) <= DEPTH + int'(pop_n)));

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush || (int'(pop_n) <= int'(count)));

endmodule

// File: rtl/dp_mseq.sv
module dp_mseq
    import dp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_pend,
    input  logic [7:0]    wr_byte,
    input  logic          rf_room,
    input  logic          ld_acc,
    input  logic [AW-1:0] ld_val,
    input  logic          ld_rd,
    input  logic          ld_inc,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    output logic          mem_re,
    output logic          wpop,
    output logic          rpush,
    output logic          wr_busy,
    output logic [AW-1:0] ptr_cur
);

    mst_e          st, st_nx;
    logic [AW-1:0] ptr_q;
    logic          tog_q;
    logic          cfg_rd_q;
    logic          cfg_inc_q;
    logic          moved;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (ld_acc)                    st_nx = ST_IDLE;
                else if (wr_pend)              st_nx = ST_WRITE;
                else if (cfg_rd_q && rf_room)  st_nx = ST_FETCH;
                else                           st_nx = ST_IDLE;
            end
            ST_WRITE: st_nx = ST_IDLE;
            ST_FETCH: st_nx = ld_acc ? ST_IDLE : ST_LAND;
            ST_LAND:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we  = 1'b0;
        mem_re  = 1'b0;
        wpop    = 1'b0;
        rpush   = 1'b0;
        wr_busy = 1'b0;
        unique case (st)
            ST_IDLE:  ;
            ST_WRITE: begin mem_we = 1'b1; wpop = 1'b1; wr_busy = 1'b1; end
            ST_FETCH: mem_re = 1'b1;
            ST_LAND:  rpush = !ld_acc;
            default:  ;
        endcase
    end

    assign moved     = mem_we || mem_re;
    assign mem_wdata = wr_byte;
    assign mem_addr  = cfg_inc_q ? ptr_q : {ptr_q[AW-1:1], tog_q};
    assign ptr_cur   = ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            tog_q     <= 1'b0;
            cfg_rd_q  <= 1'b0;
            cfg_inc_q <= 1'b0;
        end else if (ld_acc) begin
            ptr_q     <= ld_val;
            tog_q     <= 1'b0;
            cfg_rd_q  <= ld_rd;
            cfg_inc_q <= ld_inc;
        end else if (moved) begin
            if (cfg_inc_q) ptr_q <= ptr_q + 1'b1;
            else           tog_q <= ~tog_q;
        end
    end

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_inc_q && moved && !ld_acc) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_inc_q && !ld_acc) |=> $stable(ptr_q));

    // R8
    fetch_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> cfg_rd_q);

endmodule

// File: rtl/dport_top.sv
module dport_top
    import dp_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    hst_addr,
    input  logic          hst_nbhe,
    input  logic          hst_wr,
    input  logic          hst_rd,
    input  logic [15:0]   hst_wdata,
    output logic [15:0]   hst_rdata,
    output logic          hst_rdy,
    input  logic          ptr_ld,
    input  logic [AW-1:0] ptr_val,
    input  logic          ptr_rd_mode,
    input  logic          ptr_autoinc,
    output logic [AW-1:0] ptr_cur,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    output logic          mem_re,
    input  logic [7:0]    mem_rdata
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          sel;
    lane_e         lane;
    logic [1:0]    nbytes;
    logic [CW-1:0] wf_count, rf_count;
    logic [7:0]    wf_head;
    logic [15:0]   rf_head;
    logic          wr_req, rd_req;
    logic          ld_ok, ld_acc, wr_acc, rd_acc;
    logic          wpop, rpush, wr_busy;
    logic [1:0]    wf_push_n, rf_pop_n;
    logic [7:0]    wf_b0, wf_b1;

    dp_decode u_dec (
        .addr   (hst_addr),
        .nbhe   (hst_nbhe),
        .sel    (sel),
        .lane   (lane),
        .nbytes (nbytes)
    );

    assign wr_req = hst_wr && (nbytes != 2'd0);
    assign rd_req = hst_rd && (nbytes != 2'd0);
    assign ld_ok  = (wf_count == '0) && !wr_busy;

    always_comb begin
        if (ptr_ld)      hst_rdy = ld_ok;
        else if (hst_wr) hst_rdy = !wr_req || (int'(wf_count) + int'(nbytes) <= DEPTH);
        else if (hst_rd) hst_rdy = !rd_req || (int'(rf_count) >= int'(nbytes));
        else             hst_rdy = 1'b1;
    end

    assign ld_acc = ptr_ld && ld_ok;
    assign wr_acc = !ptr_ld && wr_req && hst_rdy;
    assign rd_acc = !ptr_ld && !hst_wr && rd_req && hst_rdy;

    // lane steering into the write FIFO
    always_comb begin
        wf_push_n = wr_acc ? nbytes : 2'd0;
        wf_b0     = (lane == LANE_HI) ? hst_wdata[15:8] : hst_wdata[7:0];
        wf_b1     = hst_wdata[15:8];
    end

    // lane steering out of the read FIFO
    always_comb begin
        rf_pop_n = rd_acc ? nbytes : 2'd0;
        unique case (lane)
            LANE_WORD: hst_rdata = rf_head;
            LANE_LO:   hst_rdata = {8'h00, rf_head[7:0]};
            LANE_HI:   hst_rdata = {rf_head[7:0], 8'h00};
            default:   hst_rdata = 16'h0000;
        endcase
    end

    dp_fifo #(.DEPTH(DEPTH), .HEADS(1)) u_wfifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (1'b0),
        .push_n  (wf_push_n),
        .push_b0 (wf_b0),
        .push_b1 (wf_b1),
        .pop_n   ({1'b0, wpop}),
        .head    (wf_head),
        .count   (wf_count)
    );

    dp_fifo #(.DEPTH(DEPTH), .HEADS(2)) u_rfifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (ld_acc),
        .push_n  ({1'b0, rpush}),
        .push_b0 (mem_rdata),
        .push_b1 (8'h00),
        .pop_n   (rf_pop_n),
        .head    (rf_head),
        .count   (rf_count)
    );

    dp_mseq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pend   (wf_count != '0),
        .wr_byte   (wf_head),
        .rf_room   (int'(rf_count) < DEPTH),
        .ld_acc    (ld_acc),
        .ld_val    (ptr_val),
        .ld_rd     (ptr_rd_mode),
        .ld_inc    (ptr_autoinc),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .wpop      (wpop),
        .rpush     (rpush),
        .wr_busy   (wr_busy),
        .ptr_cur   (ptr_cur)
    );

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_acc |=> (rf_count == '0));

    // R3
    drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wf_count != '0));

    // R1
    ignore_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && hst_wr && !ptr_ld) |-> (hst_rdy && !wr_acc));

endmodule

// File: tb/sim_dport_top.sv
`timescale 1ns/1ps
module sim_dport_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hst_addr = 4'h0;
    logic        hst_nbhe = 1'b1;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [15:0] hst_wdata = 16'h0;
    logic [15:0] hst_rdata;
    logic        hst_rdy;
    logic        ptr_ld = 1'b0;
    logic [7:0]  ptr_val = 8'h0;
    logic        ptr_rd_mode = 1'b0;
    logic        ptr_autoinc = 1'b0;
    logic [7:0]  ptr_cur;
    logic [7:0]  mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        mem_re;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [256];
    int          errs = 0;
    int          checks = 0;
    int          re_cnt = 0;
    logic        mon_en = 1'b0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    dport_top u0 (
        .clk(clk), .rst_n(rst_n),
        .hst_addr(hst_addr), .hst_nbhe(hst_nbhe), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rdy(hst_rdy),
        .ptr_ld(ptr_ld), .ptr_val(ptr_val), .ptr_rd_mode(ptr_rd_mode),
        .ptr_autoinc(ptr_autoinc), .ptr_cur(ptr_cur),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // byte-wide synchronous memory model, pattern loaded during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hC3;
            mem_rdata <= 8'h00;
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (mem_re) mem_rdata <= mem[mem_addr];
        end
    end

    always @(posedge clk) begin
        if (mon_en && mem_re) re_cnt <= re_cnt + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'hC3;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host(input bit is_wr, input logic [3:0] a, input logic nbhe,
                        input logic [15:0] wd, output logic [15:0] rd, output int waits);
        hst_addr = a; hst_nbhe = nbhe; hst_wdata = wd;
        hst_wr = is_wr; hst_rd = !is_wr; waits = 0;
        #1;
        while (!hst_rdy && waits < 200) begin
            @(negedge clk); #1; waits++;
        end
        rd = hst_rdata;
        @(posedge clk);
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b0;
    endtask

    task automatic load(input logic [7:0] v, input logic rdm, input logic inc, output int waits);
        ptr_val = v; ptr_rd_mode = rdm; ptr_autoinc = inc; ptr_ld = 1'b1; waits = 0;
        #1;
        while (!hst_rdy && waits < 200) begin
            @(negedge clk); #1; waits++;
        end
        @(posedge clk);
        @(negedge clk);
        ptr_ld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 ptr", 32'(ptr_cur), 32'h0);
        chk("R12 we", 32'(mem_we), 32'h0);
        chk("R12 re", 32'(mem_re), 32'h0);
        chk("R12 rdy", 32'(hst_rdy), 32'h1);
        idle(10);
        chk("R12 no fetch in write mode", 32'(mem_re), 32'h0);
    endtask

    task automatic t_write_mix();
        logic [15:0] d; int w;
        load(8'h10, 1'b0, 1'b1, w);
        host(1, 4'h8, 1'b0, 16'h2211, d, w);   // word
        host(1, 4'h8, 1'b1, 16'h0033, d, w);   // low byte
        host(1, 4'h9, 1'b0, 16'h4400, d, w);   // high byte
        host(1, 4'hA, 1'b0, 16'h6655, d, w);   // word at second location
        idle(30);
        for (int i = 0; i < 6; i++)
            chk("R3 R2 write stream", 32'(mem[8'h10 + i]), 32'(8'h11 * (i + 1)));
        chk("R6 ptr after 6 bytes", 32'(ptr_cur), 32'h16);
    endtask

    task automatic t_write_odd();
        logic [15:0] d; int w;
        load(8'h21, 1'b0, 1'b1, w);
        host(1, 4'hA, 1'b0, 16'hBBAA, d, w);
        idle(20);
        chk("R5 odd write lo", 32'(mem[8'h21]), 32'hAA);
        chk("R5 odd write hi", 32'(mem[8'h22]), 32'hBB);
    endtask

    task automatic t_ignore();
        logic [15:0] d; int w;
        load(8'h90, 1'b0, 1'b1, w);
        host(1, 4'h4, 1'b0, 16'hEEEE, d, w);   // outside window
        host(1, 4'h9, 1'b1, 16'hDDDD, d, w);   // no lane enabled
        host(1, 4'h8, 1'b0, 16'h0201, d, w);
        idle(20);
        chk("R1 first byte", 32'(mem[8'h90]), 32'h01);
        chk("R1 second byte", 32'(mem[8'h91]), 32'h02);
        chk("R2 untouched", 32'(mem[8'h92]), 32'(pat(8'h92)));
        chk("R1 ptr", 32'(ptr_cur), 32'h92);
    endtask

    task automatic t_read_mix();
        logic [15:0] d; int w;
        load(8'h40, 1'b1, 1'b1, w);
        idle(30);
        chk("R8 prefetch stops at depth", 32'(ptr_cur), 32'h44);
        host(0, 4'h8, 1'b0, 16'h0, d, w);
        chk("R4 word", 32'(d), 32'({pat(8'h41), pat(8'h40)}));
        host(0, 4'h8, 1'b1, 16'h0, d, w);
        chk("R4 low byte", 32'(d), 32'({8'h00, pat(8'h42)}));
        host(0, 4'h9, 1'b0, 16'h0, d, w);
        chk("R4 high byte", 32'(d), 32'({pat(8'h43), 8'h00}));
        host(0, 4'hA, 1'b0, 16'h0, d, w);
        chk("R4 word after bytes", 32'(d), 32'({pat(8'h45), pat(8'h44)}));
        idle(30);
        chk("R6 R8 ptr after refill", 32'(ptr_cur), 32'h4A);
    endtask

    task automatic t_read_odd_stall();
        logic [15:0] d; int w;
        load(8'h51, 1'b1, 1'b1, w);
        host(0, 4'h8, 1'b0, 16'h0, d, w);
        chk("R10 read stalled", 32'(w > 0), 32'h1);
        chk("R5 R10 odd word", 32'(d), 32'({pat(8'h52), pat(8'h51)}));
    endtask

    task automatic t_fixed_ptr();
        logic [15:0] d; int w;
        load(8'h30, 1'b0, 1'b0, w);
        host(1, 4'h8, 1'b0, 16'h7170, d, w);
        host(1, 4'h8, 1'b0, 16'h7372, d, w);
        idle(20);
        chk("R7 even byte", 32'(mem[8'h30]), 32'h72);
        chk("R7 odd byte", 32'(mem[8'h31]), 32'h73);
        chk("R7 ptr held (write)", 32'(ptr_cur), 32'h30);
        load(8'h60, 1'b1, 1'b0, w);
        idle(20);
        host(0, 4'h8, 1'b0, 16'h0, d, w);
        chk("R7 read word 1", 32'(d), 32'({pat(8'h61), pat(8'h60)}));
        host(0, 4'h8, 1'b0, 16'h0, d, w);
        chk("R7 read word 2", 32'(d), 32'({pat(8'h61), pat(8'h60)}));
        chk("R7 ptr held (read)", 32'(ptr_cur), 32'h60);
    endtask

    task automatic t_flush();
        logic [15:0] d; int w;
        load(8'h40, 1'b1, 1'b1, w);
        idle(3);
        load(8'h70, 1'b1, 1'b1, w);
        host(0, 4'h8, 1'b0, 16'h0, d, w);
        chk("R9 data from new pointer", 32'(d), 32'({pat(8'h71), pat(8'h70)}));
        host(0, 4'h8, 1'b1, 16'h0, d, w);
        chk("R9 next byte", 32'(d), 32'({8'h00, pat(8'h72)}));
        idle(30);
        load(8'h78, 1'b1, 1'b1, w);
        host(0, 4'hA, 1'b0, 16'h0, d, w);
        chk("R9 full fifo flushed", 32'(d), 32'({pat(8'h79), pat(8'h78)}));
    endtask

    task automatic t_write_mode_nofetch();
        int w;
        load(8'hC0, 1'b0, 1'b1, w);
        re_cnt = 0;
        mon_en = 1'b1;
        idle(20);
        mon_en = 1'b0;
        chk("R8 no reads in write mode", 32'(re_cnt), 32'h0);
        chk("R8 ptr unmoved", 32'(ptr_cur), 32'hC0);
    endtask

    task automatic t_write_stall();
        logic [15:0] d; int w; int stalls;
        stalls = 0;
        load(8'hA0, 1'b0, 1'b1, w);
        for (int k = 0; k < 4; k++) begin
            host(1, 4'h8, 1'b0, {8'(2 * k + 1), 8'(2 * k)}, d, w);
            stalls += w;
        end
        chk("R11 write stalled", 32'(stalls > 0), 32'h1);
        load(8'h40, 1'b1, 1'b1, w);
        chk("R11 load held off", 32'(w > 0), 32'h1);
        for (int i = 0; i < 8; i++)
            chk("R11 R3 data kept", 32'(mem[8'hA0 + i]), 32'(i));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_mix();
        t_write_odd();
        t_ignore();
        t_read_mix();
        t_read_odd_stall();
        t_fixed_ptr();
        t_flush();
        t_write_mode_nofetch();
        t_write_stall();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule